// File: doc/BRIEF.md
# Timer Clock Source Selector

This block decides, cycle by cycle, whether a timer counter advances. A 3-bit select code chooses the source of the count-enable pulse. The choices are: nothing, in which case the counter is frozen; every system clock cycle; one of four fixed division ratios of the system clock; or transitions of an external pin, counted on either the falling or the rising edge. The result is a registered, single-cycle pulse that the counter uses as its increment enable.

Inside the block, a free-running 10-bit prescaler supplies the divide-by-8, 64, 256 and 1024 taps. The prescaler keeps counting whatever the select code is, so all divided sources share one phase grid, and that grid is set by reset alone. The external pin goes through a two-flop synchronizer and then an edge detector. The detector follows the pin's level only, so transitions are counted even when the pin is being driven as an output by the same chip.

Top module: `tmr_clk_select`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `cnt_en` is 0 in the following cycle. Reset also clears the prescaler and the pin history.
- R2: With select code 3'b000, `cnt_en` stays 0, whatever the pin does.
- R3: With select code 3'b001, `cnt_en` is 1 in every cycle.
- R4: Select codes 3'b010, 3'b011, 3'b100 and 3'b101 give divide ratios 8, 64, 256 and 1024. `cnt_en` is 1 exactly in the k-th cycle after reset release (k counted from 1) when (k-1) is a multiple of the ratio.
- R5: With select code 3'b110, each falling edge of `ext_pin` produces exactly one pulse.
- R6: With select code 3'b111, each rising edge of `ext_pin` produces exactly one pulse.
- R7: Except in code 3'b001, `cnt_en` is never high in two consecutive cycles.
- R8: A change of select code does not reset the prescaler. The grid of R4 stays referenced to reset release across code changes.
- R9: A source that is not selected has no effect. Pin activity does not disturb the divided modes, and prescaler taps produce no pulse in the pin modes.
- R10: A counted pin transition that is set up before clock edge E0 gives a pulse on `cnt_en` in the cycle that follows edge E2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel | input | 3 | Count source select code |
| ext_pin | input | 1 | External pin level, asynchronous to `clk` |
| cnt_en | output | 1 | Registered single-cycle count-enable pulse |

## Verification
A prescaler tap and a detected pin edge can land in the same cycle, and only the source named by the select code may pass through. To provoke this, the bench toggles the pin every third cycle while a divided mode is active, so pin edges fall on and around tap cycles. It then requires the output to match the reset-referenced divide grid exactly, cycle for cycle. In the opposite direction, a pin mode is held with a quiet pin for longer than the largest divide period, and no pulse may appear.

// File: rtl/tcs_pkg.sv
// Shared types and constants for the timer clock source selector.
// Assumes the four prescaler taps are ordered from the smallest ratio to the largest.
package tcs_pkg;

    localparam int unsigned TAP_COUNT = 4;

    typedef enum logic [2:0] {
        SRC_OFF      = 3'b000,
        SRC_DIRECT   = 3'b001,
        SRC_DIV8     = 3'b010,
        SRC_DIV64    = 3'b011,
        SRC_DIV256   = 3'b100,
        SRC_DIV1024  = 3'b101,
        SRC_PIN_FALL = 3'b110,
        SRC_PIN_RISE = 3'b111
    } src_sel_e;

    // log2 of the divide ratio of each tap
    function automatic int unsigned tap_log2(input int unsigned idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/tcs_prescaler.sv
// Free-running prescaler that produces one-cycle tap strobes.
// Tap i is high while the low tap_log2(i) bits of the counter are zero.
// Assumes PRE_W is at least the largest tap_log2 value. The counter is cleared only by reset.
module tcs_prescaler
    import tcs_pkg::*;
#(
    parameter int unsigned PRE_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic [TAP_COUNT-1:0] tap
);

    logic [PRE_W-1:0] cnt_q;

    // Count up every cycle; wrap naturally at 2**PRE_W.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    for (genvar i = 0; i < TAP_COUNT; i++) begin : g_tap
        localparam int unsigned LW = tap_log2(i);
        // Strobe when this tap's low bits wrap to zero.
        assign tap[i] = (cnt_q[LW-1:0] == '0);
    end

endmodule

// File: rtl/tcs_pin_edge.sv
// Synchronizes the external pin and flags its rising and falling edges.
// The pin level is watched regardless of pin direction. Each edge gives exactly one
// one-cycle flag. Assumes SYNC_STAGES >= 2.
module tcs_pin_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   hist_q;
    logic                   level;

    // Shift the pin through the synchronizer and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            hist_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            hist_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign level = sync_q[SYNC_STAGES-1];
    assign rise  = level & ~hist_q;
    assign fall  = ~level & hist_q;

endmodule

// File: rtl/tcs_source_mux.sv
// Picks the count source named by the select code and registers the result.
// Assumes the tap strobes and edge flags are already one cycle wide.
module tcs_source_mux
    import tcs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           sel,
    input  logic [TAP_COUNT-1:0] tap,
    input  logic                 rise,
    input  logic                 fall,
    output logic                 cnt_en
);

    logic pick;

    // Route the selected source to the output register.
    always_comb begin
        case (src_sel_e'(sel))
            SRC_OFF:      pick = 1'b0;
            SRC_DIRECT:   pick = 1'b1;
            SRC_DIV8:     pick = tap[0];
            SRC_DIV64:    pick = tap[1];
            SRC_DIV256:   pick = tap[2];
            SRC_DIV1024:  pick = tap[3];
            SRC_PIN_FALL: pick = fall;
            SRC_PIN_RISE: pick = rise;
            default:      pick = 1'b0;
        endcase
    end

    // Register the pulse so the output is glitch free and clock aligned.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_en <= 1'b0;
        else        cnt_en <= pick;
    end

endmodule

// File: rtl/tmr_clk_select.sv
// Top of the timer clock source selector.
// Produces a one-cycle count-enable from a stopped state, the system clock, four
// prescaled taps or external pin edges. Assumes ext_pin is asynchronous to clk.
module tmr_clk_select
    import tcs_pkg::*;
#(
    parameter int unsigned PRE_W       = 10,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    input  logic       ext_pin,
    output logic       cnt_en
);

    logic [TAP_COUNT-1:0] tap;
    logic                 pin_rise;
    logic                 pin_fall;

    tcs_prescaler #(.PRE_W(PRE_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tap   (tap)
    );

    tcs_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_pin),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    tcs_source_mux u_mux (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel),
        .tap    (tap),
        .rise   (pin_rise),
        .fall   (pin_fall),
        .cnt_en (cnt_en)
    );

endmodule

// File: rtl/tcs_checker.sv
// Port-level properties of the timer clock source selector, bound into the top.
module tcs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] sel,
    input logic       cnt_en
);

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !cnt_en); // R1

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 3'b000) |=> !cnt_en); // R2

    AST_DIRECT_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 3'b001) |=> cnt_en); // R3

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && sel != 3'b001 && $past(sel) != 3'b001) |=> !cnt_en); // R7

endmodule

bind tmr_clk_select tcs_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (sel),
    .cnt_en (cnt_en)
);

// File: tb/tmr_clk_select_tb.sv
`timescale 1ns/1ps
module tmr_clk_select_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel = 3'b000;
    logic       ext_pin = 1'b0;
    logic       cnt_en;
    int unsigned ncyc;
    int errs = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    // Rising edges since reset release, the reference for the divide grid.
    always @(posedge clk) begin
        if (!rst_n) ncyc <= 0;
        else        ncyc <= ncyc + 1;
    end

    tmr_clk_select u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .ext_pin (ext_pin),
        .cnt_en  (cnt_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        sel   = 3'b001;
        repeat (4) @(negedge clk);
        chk(cnt_en == 1'b0, "R1 output idle in reset", int'(cnt_en), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_direct();
        int highs = 0;
        sel = 3'b001;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (cnt_en) highs++;
        end
        chk(highs == 40, "R3 every cycle", highs, 40);
    endtask

    task automatic t_off();
        int highs = 0;
        sel = 3'b000;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (i % 2 == 0) ext_pin = ~ext_pin;
            if (cnt_en) highs++;
        end
        ext_pin = 1'b0;
        repeat (4) @(negedge clk);
        chk(highs == 0, "R2 stopped", highs, 0);
    endtask

    // Grid check: pulse exactly when (ncyc-1) is a multiple of the ratio.
    task automatic t_div(input logic [2:0] code, input int unsigned ratio,
                         input int cycles, input bit toggle);
        int bad = 0;
        int highs = 0;
        int first_act = 0;
        int first_exp = 0;
        bit exp_v;
        sel = code;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (toggle && (i % 3 == 0)) ext_pin = ~ext_pin;
            exp_v = ((ncyc - 1) % ratio) == 0;
            if (cnt_en) highs++;
            if (cnt_en !== exp_v) begin
                if (bad == 0) begin
                    first_act = int'(cnt_en);
                    first_exp = int'(exp_v);
                end
                bad++;
            end
        end
        ext_pin = 1'b0;
        repeat (4) @(negedge clk);
        // R4 and R8: grid referenced to reset; R9 when the pin toggles
        chk(bad == 0, toggle ? "R4 R8 R9 divided grid with pin noise" : "R4 R8 divided grid",
            first_act, first_exp);
        chk(highs >= cycles / int'(ratio), "R4 pulse count", highs, cycles / int'(ratio));
    endtask

    task automatic t_pin(input logic [2:0] code, input string req);
        int pulses = 0;
        int width_bad = 0;
        int late = 0;
        bit prev = 1'b0;
        bit counted;
        sel = code;
        repeat (4) @(negedge clk);
        for (int e = 0; e < 6; e++) begin
            ext_pin = ~ext_pin;
            counted = (code == 3'b111) ? ext_pin : ~ext_pin;
            for (int j = 0; j < 6; j++) begin
                @(negedge clk);
                if (cnt_en) pulses++;
                if (cnt_en && prev) width_bad++;
                // R10: pulse only at sample 2 after a counted transition
                if (cnt_en !== (counted && j == 2)) late++;
                prev = cnt_en;
            end
        end
        chk(pulses == 3, req, pulses, 3);
        chk(width_bad == 0, "R7 single-cycle pin pulse", width_bad, 0);
        chk(late == 0, "R10 pin latency", late, 0);
    endtask

    task automatic t_pin_quiet();
        int highs = 0;
        sel = 3'b111;
        ext_pin = 1'b0;
        for (int i = 0; i < 2100; i++) begin
            @(negedge clk);
            if (cnt_en) highs++;
        end
        chk(highs == 0, "R9 taps ignored in pin mode", highs, 0);
    endtask

    initial begin
        #(200000 * 5);
        errs++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_direct();
        t_off();
        t_div(3'b010, 8,    100,  1'b1);
        t_div(3'b011, 64,   200,  1'b0);
        t_div(3'b100, 256,  600,  1'b1);
        t_div(3'b101, 1024, 2200, 1'b0);
        t_pin(3'b111, "R6 rising edges");
        t_pin(3'b110, "R5 falling edges");
        t_pin_quiet();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule